// File: doc/BRIEF.md
# Regulator Soft-Start Reference Ramp with Short-Circuit Timeout

This block drives the digital reference code of one switching-regulator channel while it starts up. When enabled, the code climbs from zero by one code step at a fixed pace derived from the clock rate. That pace matches a soft-start slope of about 30 mV per microsecond with a 5 mV code step. A digitized feedback of the real output is compared against a handover level near 0.3 V. Once the output reaches that level, the block stops the fixed ramp and moves the reference toward the target in bounded slew steps, upward or downward.

The same feedback is watched for a short circuit. If the output has never been above a fault level near 0.35 V when a 1 ms window measured from the enable edge closes, the channel is shut off. The reference is forced to zero and a sticky fault flag is raised. A power-good comparison against a fixed fraction of the target sets a second sticky flag, which a mask bit keeps off the combined interrupt line. Both flags are cleared by write-one-to-clear pulses. Dropping the enable returns the block to rest, and the next enable restarts the ramp from zero.

Top module: `vref_softstart`

## Requirements
- R1: While reset is held, and after it, with enable low, refCode, chanOff, pgGood, faultFlag, pgFlag and irq are all 0.
- R2: In soft-start, refCode rises by exactly one code every SS_DIV clocks (LSB_UV*CLK_MHZ/SS_RATE_UV_PER_US, minimum 1). The value N clocks after the enable edge is floor(N/SS_DIV), and it holds at the target code instead of passing it.
- R3: On the first clock edge at which fbCode >= HANDOVER_UV/LSB_UV during soft-start, the block switches to slew control. From then on, every SLEW_DIV clocks refCode moves toward the target by SLEW_STEP codes, or by the remaining gap if that is smaller, in either direction.
- R4: If fbCode has not exceeded FAULT_UV/LSB_UV by the edge TIMEOUT_US*CLK_MHZ clocks after the enable edge, then at that edge chanOff and faultFlag become 1 and refCode becomes 0. All three stay so while enable stays high.
- R5: fbCode strictly above the fault code, seen on any edge up to and including the last edge before the window closes, prevents the fault. fbCode equal to the fault code does not.
- R6: pgGood is 1 one edge after fbCode >= floor(target*PG_NUM/PG_DEN) is seen while the channel runs. It is 0 one edge after enable is sampled low or a fault is taken.
- R7: pgFlag is set on the edge where pgGood rises and stays set while pgGood stays high.
- R8: A clrFault or clrPg pulse clears its flag on the next edge. If the set condition of a flag coincides with its clear pulse, the flag ends up set.
- R9: irq equals faultFlag OR (pgFlag AND NOT pgMask), combinationally. pgMask does not alter pgFlag.
- R10: Enable sampled low forces refCode to 0 and clears chanOff on that edge. A later enable restarts the ramp from code 0, including after a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Channel enable |
| target | input | CODE_W | Target output code |
| fbCode | input | CODE_W | Digitized output-voltage feedback |
| pgMask | input | 1 | 1 keeps the power-good flag off irq |
| clrFault | input | 1 | Write-one-to-clear pulse for faultFlag |
| clrPg | input | 1 | Write-one-to-clear pulse for pgFlag |
| refCode | output | CODE_W | Reference code to the regulator loop |
| chanOff | output | 1 | Channel shut off by short-circuit timeout |
| pgGood | output | 1 | Output is at or above the power-good level |
| faultFlag | output | 1 | Sticky short-circuit interrupt flag |
| pgFlag | output | 1 | Sticky power-good interrupt flag |
| irq | output | 1 | Combined interrupt line |

## Verification
A flag's set event can land on the same edge as its write-one-to-clear pulse. The short-circuit timeout can meet clrFault, and a rising power-good comparison can meet clrPg. The bench provokes both cases by raising the clear pulse on the clock before the timeout edge, and again together with the feedback step that crosses the power-good level. After that edge it expects the flag to read 1. A second same-edge case is the feedback rising above the fault code on the last clock of the window, against the timeout firing. The bench expects chanOff to stay 0 there.

// File: rtl/rampguard_pkg.sv
package rampguard_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SOFT  = 2'd1,
    ST_SLEW  = 2'd2,
    ST_FAULT = 2'd3
  } rampPhase_t;

  // strobes from the sequencer to the reference datapath
  typedef struct packed {
    logic zero;      // force reference to 0 on this edge
    logic ssInc;     // soft-start single-code step
    logic slewTick;  // slew step toward target
    logic faultSet;  // short-circuit timeout taken on this edge
    logic active;    // channel running, power-good may be judged
  } rampStb_t;

endpackage

// File: rtl/rampguard_ctrl.sv
module rampguard_ctrl
  import rampguard_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int SS_DIV      = 33,
  parameter int SLEW_DIV    = 20,
  parameter int TIMEOUT_CYC = 200000,
  parameter int HAND_CODE   = 60,
  parameter int FAULT_CODE  = 70
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [CODE_W-1:0] fbCode,
  output rampStb_t          stb,
  output logic              chanOff
);

  localparam int SS_W  = $clog2(SS_DIV) + 1;
  localparam int SL_W  = $clog2(SLEW_DIV) + 1;
  localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CODE_W-1:0] HAND_C  = CODE_W'(HAND_CODE);
  localparam logic [CODE_W-1:0] FAULT_C = CODE_W'(FAULT_CODE);
  localparam logic [SS_W-1:0]   SS_LAST = SS_W'(SS_DIV - 1);
  localparam logic [SL_W-1:0]   SL_LAST = SL_W'(SLEW_DIV - 1);
  localparam logic [TMR_W-1:0]  TMR_LAST = TMR_W'(TIMEOUT_CYC - 1);

  rampPhase_t       state;
  logic [SS_W-1:0]  ssCnt;
  logic [SL_W-1:0]  slCnt;
  logic [TMR_W-1:0] timer;
  logic             risen;
  logic             running;
  logic             faultHit;
  logic             ssTick;

  // a one-clock soft-start divider needs no counter
  generate
    if (SS_DIV == 1) begin : g_ssEvery
      assign ssTick = 1'b1;
    end else begin : g_ssDiv
      assign ssTick = (ssCnt == SS_LAST);
    end
  endgenerate

  always_comb begin
    running  = (state == ST_SOFT) || (state == ST_SLEW);
    faultHit = running && en && !risen && (fbCode <= FAULT_C) && (timer == TMR_LAST);
    stb.faultSet = faultHit;
    stb.ssInc    = (state == ST_SOFT) && ssTick;
    stb.slewTick = (state == ST_SLEW) && (slCnt == SL_LAST);
    stb.zero     = !(running && en) || faultHit;
    stb.active   = running && en && !faultHit;
  end

  assign chanOff = (state == ST_FAULT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      ssCnt <= '0;
      slCnt <= '0;
      timer <= '0;
      risen <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (en) begin
            state <= ST_SOFT;
            ssCnt <= '0;
            slCnt <= '0;
            timer <= '0;
            risen <= 1'b0;
          end
        end
        ST_SOFT, ST_SLEW: begin
          if (!en) begin
            state <= ST_IDLE;
          end else if (faultHit) begin
            state <= ST_FAULT;
          end else begin
            if (state == ST_SOFT) begin
              ssCnt <= (ssCnt == SS_LAST) ? '0 : ssCnt + 1'b1;
              if (fbCode >= HAND_C) begin
                state <= ST_SLEW;
                slCnt <= '0;
              end
            end else begin
              slCnt <= (slCnt == SL_LAST) ? '0 : slCnt + 1'b1;
            end
            if (!risen) timer <= timer + 1'b1;
            if (fbCode > FAULT_C) risen <= 1'b1;
          end
        end
        ST_FAULT: begin
          if (!en) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: feedback at the handover level during soft-start moves to slew control
  p_handover_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SOFT) && en && !faultHit && (fbCode >= HAND_C) |=> (state == ST_SLEW));

  // R4: a taken fault holds as long as enable stays high
  p_fault_hold_r4: assert property (@(posedge clk) disable iff (rst)
    chanOff && en |=> chanOff);

  // R10: enable low always ends a shut-off
  p_release_r10: assert property (@(posedge clk) disable iff (rst)
    !en |=> !chanOff);

endmodule

// File: rtl/rampguard_path.sv
module rampguard_path
  import rampguard_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int SLEW_STEP = 2,
  parameter int PG_NUM    = 9,
  parameter int PG_DEN    = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  rampStb_t          stb,
  input  logic [CODE_W-1:0] target,
  input  logic [CODE_W-1:0] fbCode,
  input  logic              pgMask,
  input  logic              clrFault,
  input  logic              clrPg,
  output logic [CODE_W-1:0] refCode,
  output logic              pgGood,
  output logic              faultFlag,
  output logic              pgFlag,
  output logic              irq
);

  localparam int MUL_W = CODE_W + $clog2(PG_NUM + 1);
  localparam logic [CODE_W-1:0] STEP_C = CODE_W'(SLEW_STEP);

  logic [CODE_W-1:0] refNext;
  logic [CODE_W-1:0] gapUp;
  logic [CODE_W-1:0] gapDn;
  logic [MUL_W-1:0]  pgThr;
  logic              pgLevel;

  always_comb begin
    gapUp   = target - refCode;
    gapDn   = refCode - target;
    refNext = refCode;
    if (stb.zero) begin
      refNext = '0;
    end else if (stb.ssInc) begin
      if (refCode < target) refNext = refCode + 1'b1;
    end else if (stb.slewTick) begin
      if (refCode < target) begin
        refNext = (gapUp > STEP_C) ? refCode + STEP_C : target;
      end else if (refCode > target) begin
        refNext = (gapDn > STEP_C) ? refCode - STEP_C : target;
      end
    end
  end

  always_comb begin
    pgThr   = (MUL_W'(target) * MUL_W'(PG_NUM)) / MUL_W'(PG_DEN);
    pgLevel = stb.active && (MUL_W'(fbCode) >= pgThr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      refCode   <= '0;
      pgGood    <= 1'b0;
      faultFlag <= 1'b0;
      pgFlag    <= 1'b0;
    end else begin
      refCode   <= refNext;
      pgGood    <= pgLevel;
      faultFlag <= (faultFlag && !clrFault) || stb.faultSet;
      pgFlag    <= (pgFlag && !clrPg) || (pgLevel && !pgGood);
    end
  end

  assign irq = faultFlag || (pgFlag && !pgMask);

  // R2: a soft-start strobe below target advances the code by exactly one
  p_soft_step_r2: assert property (@(posedge clk) disable iff (rst)
    stb.ssInc && !stb.zero && (refCode < target) |=> refCode == $past(refCode) + 1'b1);

  // R3: a slew strobe never moves the code by more than one step
  p_slew_bound_r3: assert property (@(posedge clk) disable iff (rst)
    stb.slewTick && !stb.zero |=>
      (($past(refCode) <= refCode) ? (refCode - $past(refCode) <= STEP_C)
                                   : ($past(refCode) - refCode <= STEP_C)));

  // R10: a zero strobe leaves the reference at zero
  p_zero_r10: assert property (@(posedge clk) disable iff (rst)
    stb.zero |=> refCode == '0);

  // R6: power-good drops once the channel stops running
  p_pg_off_r6: assert property (@(posedge clk) disable iff (rst)
    !stb.active |=> !pgGood);

  // R8: a set flag survives until a clear pulse
  p_fault_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    faultFlag && !clrFault |=> faultFlag);

endmodule

// File: rtl/vref_softstart.sv
module vref_softstart
  import rampguard_pkg::*;
#(
  parameter int CODE_W             = 8,
  parameter int LSB_UV             = 5000,
  parameter int CLK_MHZ            = 200,
  parameter int SS_RATE_UV_PER_US  = 30000,
  parameter int HANDOVER_UV        = 300000,
  parameter int FAULT_UV           = 350000,
  parameter int TIMEOUT_US         = 1000,
  parameter int SLEW_STEP          = 2,
  parameter int SLEW_DIV           = 20,
  parameter int PG_NUM             = 9,
  parameter int PG_DEN             = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [CODE_W-1:0] target,
  input  logic [CODE_W-1:0] fbCode,
  input  logic              pgMask,
  input  logic              clrFault,
  input  logic              clrPg,
  output logic [CODE_W-1:0] refCode,
  output logic              chanOff,
  output logic              pgGood,
  output logic              faultFlag,
  output logic              pgFlag,
  output logic              irq
);

  localparam int SS_DIV_RAW  = (LSB_UV * CLK_MHZ) / SS_RATE_UV_PER_US;
  localparam int SS_DIV      = (SS_DIV_RAW < 1) ? 1 : SS_DIV_RAW;
  localparam int HAND_CODE   = HANDOVER_UV / LSB_UV;
  localparam int FAULT_CODE  = FAULT_UV / LSB_UV;
  localparam int TIMEOUT_CYC = TIMEOUT_US * CLK_MHZ;

  rampStb_t stb;

  rampguard_ctrl #(
    .CODE_W(CODE_W), .SS_DIV(SS_DIV), .SLEW_DIV(SLEW_DIV),
    .TIMEOUT_CYC(TIMEOUT_CYC), .HAND_CODE(HAND_CODE), .FAULT_CODE(FAULT_CODE)
  ) u_ctrl (
    .clk(clk), .rst(rst), .en(en), .fbCode(fbCode),
    .stb(stb), .chanOff(chanOff)
  );

  rampguard_path #(
    .CODE_W(CODE_W), .SLEW_STEP(SLEW_STEP), .PG_NUM(PG_NUM), .PG_DEN(PG_DEN)
  ) u_path (
    .clk(clk), .rst(rst), .stb(stb), .target(target), .fbCode(fbCode),
    .pgMask(pgMask), .clrFault(clrFault), .clrPg(clrPg),
    .refCode(refCode), .pgGood(pgGood), .faultFlag(faultFlag),
    .pgFlag(pgFlag), .irq(irq)
  );

  // R4: a shut-off channel always presents a zero reference
  p_fault_zero_r4: assert property (@(posedge clk) disable iff (rst)
    chanOff |-> refCode == '0);

endmodule

// File: tb/sim_vref_softstart.sv
module sim_vref_softstart;

  localparam int CW    = 8;
  localparam int MHZ   = 12;
  localparam int TUS   = 20;
  localparam int STEP  = 3;
  localparam int SDIV  = 4;
  localparam int SSD   = 2;     // 5000*12/30000
  localparam int TCYC  = 240;   // 20 us * 12 clocks
  localparam int HAND  = 60;    // 300 mV / 5 mV
  localparam int FLT   = 70;    // 350 mV / 5 mV

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en = 1'b0;
  logic [CW-1:0] target = '0;
  logic          forceFb = 1'b1;
  logic [CW-1:0] fbForced = '0;
  logic          pgMask = 1'b0;
  logic          clrFault = 1'b0;
  logic          clrPg = 1'b0;
  logic [CW-1:0] fbCode;
  logic [CW-1:0] refCode;
  logic          chanOff, pgGood, faultFlag, pgFlag, irq;

  int nChk = 0;
  int nFail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  // ideal plant: output follows the reference unless the bench pins it
  assign fbCode = forceFb ? fbForced : refCode;

  vref_softstart #(
    .CODE_W(CW), .CLK_MHZ(MHZ), .TIMEOUT_US(TUS),
    .SLEW_STEP(STEP), .SLEW_DIV(SDIV)
  ) u0 (
    .clk(clk), .rst(rst), .en(en), .target(target), .fbCode(fbCode),
    .pgMask(pgMask), .clrFault(clrFault), .clrPg(clrPg),
    .refCode(refCode), .chanOff(chanOff), .pgGood(pgGood),
    .faultFlag(faultFlag), .pgFlag(pgFlag), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int minI(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // enable is raised at a negedge; after step(1) the bench sits N=0 clocks past the enable edge
  task automatic startRun();
    en = 1'b1;
    step(1);
  endtask

  task automatic stopRun();
    en = 1'b0;
    step(1);
  endtask

  initial begin
    step(3);
    chk("R1 ref in reset", refCode, 0);
    chk("R1 chanOff in reset", chanOff, 0);
    rst = 1'b0;
    step(2);
    chk("R1 idle ref", refCode, 0);
    chk("R1 idle flags", {pgGood, faultFlag, pgFlag, irq, chanOff}, 0);

    // soft-start with the output pinned at 0: full ramp, cap, timeout
    target = 8'd100; forceFb = 1'b1; fbForced = '0;
    startRun();
    for (int n = 0; n < TCYC; n++) begin
      chk($sformatf("R2 soft ramp N=%0d", n), refCode, minI(n / SSD, 100));
      if (n == TCYC - 1) begin
        chk("R4 no shut-off before window", chanOff, 0);
        clrFault = 1'b1;  // R8: clear lands on the fault edge
      end
      if (n < TCYC - 1) step(1);
    end
    step(1);
    clrFault = 1'b0;
    chk("R4 shut-off at window end", chanOff, 1);
    chk("R4 ref zero on fault", refCode, 0);
    chk("R8 fault set wins over clear", faultFlag, 1);
    chk("R9 irq from fault", irq, 1);
    step(5);
    chk("R4 fault holds", {chanOff, refCode}, {1'b1, 8'd0});
    clrFault = 1'b1; step(1); clrFault = 1'b0;
    chk("R8 fault clear", faultFlag, 0);
    chk("R9 irq after clear", irq, 0);
    stopRun();
    chk("R10 enable low releases", chanOff, 0);

    // R10 restart after a fault, closed loop: ramp, handover, slew, power-good
    forceFb = 1'b0;
    startRun();
    for (int n = 0; n <= 185; n++) begin
      int e;
      e = (n <= 120) ? n / SSD : minI(HAND + STEP * ((n - 121) / SDIV), 100);
      chk($sformatf("R3 closed loop ref N=%0d", n), refCode, e);
      chk($sformatf("R6 pgGood N=%0d", n), pgGood, (n >= 162) ? 1 : 0);
      step(1);
    end
    chk("R7 pg flag set", pgFlag, 1);
    step(60);
    chk("R5 risen output avoids fault", chanOff, 0);
    chk("R7 pg flag sticky", pgFlag, 1);
    pgMask = 1'b1; #1;
    chk("R9 masked irq", irq, 0);
    chk("R9 mask keeps flag", pgFlag, 1);
    pgMask = 1'b0; #1;
    chk("R9 unmasked irq", irq, 1);
    step(1);
    clrPg = 1'b1; step(1); clrPg = 1'b0;
    chk("R8 pg clear", pgFlag, 0);
    step(4);
    chk("R7 no set without new rise", pgFlag, 0);

    // R3 downward slew
    begin
      int prev;
      bit bad;
      bad = 0;
      target = 8'd40;
      prev = refCode;
      for (int i = 0; i < 100; i++) begin
        step(1);
        if (refCode > prev || prev - refCode > STEP) bad = 1;
        prev = refCode;
      end
      chk("R3 down steps bounded", bad, 0);
      chk("R3 down lands on target", refCode, 40);
      chk("R6 pg holds at new target", pgGood, 1);
    end
    stopRun();
    chk("R10 ref zero on disable", refCode, 0);
    chk("R6 pg drops on disable", pgGood, 0);

    // R5 feedback equal to fault code still faults
    target = 8'd100; forceFb = 1'b1; fbForced = FLT;
    startRun();
    step(TCYC - 1);
    chk("R5 equal level before window", chanOff, 0);
    step(1);
    chk("R5 equal level faults", chanOff, 1);
    stopRun();
    clrFault = 1'b1; step(1); clrFault = 1'b0;

    // R5 one code above, from start
    fbForced = FLT + 1;
    startRun();
    step(TCYC);
    chk("R5 above level no fault", chanOff, 0);
    stopRun();

    // R5 rise on the last clock of the window
    fbForced = '0;
    startRun();
    step(TCYC - 1);
    fbForced = FLT + 1;
    step(1);
    chk("R5 last-clock rise no fault", chanOff, 0);
    chk("R5 last-clock rise no flag", faultFlag, 0);
    stopRun();

    // R3 exact slew from a start already above handover; R6/R8 power-good boundary
    fbForced = 8'd75;
    startRun();
    for (int n = 0; n <= 140; n++) begin
      int e;
      e = (n < 1) ? 0 : minI(STEP * ((n - 1) / SDIV), 100);
      chk($sformatf("R3 slew ref N=%0d", n), refCode, e);
      step(1);
    end
    fbForced = 8'd89;
    step(2);
    chk("R6 below pg level", pgGood, 0);
    fbForced = 8'd90;
    clrPg = 1'b1;  // R8: clear meets the rising power-good
    step(1);
    clrPg = 1'b0;
    chk("R6 at pg level", pgGood, 1);
    chk("R8 pg set wins over clear", pgFlag, 1);
    stopRun();
    chk("R6 pg off after disable", pgGood, 0);

    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

endmodule